// File: doc/BRIEF.md
# Grouped Vector Register Contiguous Store Sequencer

This block executes one multi-register vector store. Given a store instruction word, a 64-bit base value and a count of active elements, it reads two or four consecutive vector registers. It then emits one 32-bit write request for each active element over a valid/ready memory port. Element addresses are contiguous. They start at the base plus a signed immediate that is scaled by the byte size of the whole register group.

The walk visits every element position of the group in order. The address grows by 4 bytes at every position, whether or not a write is issued there. The elements that write are those whose flattened position in the group is below the predicate count. When the base register field names the stack pointer, a 16-byte alignment check can turn the operation into a one-cycle fault with no writes. A configuration input decides whether that check applies when no element is active. Caches, address translation and the memory itself lie outside the block.

Top module: `vstore_seq`

## Requirements
- R1: Instruction bit 15 selects the group size: 0 stores 2 registers starting at register bits[4:1] times 2, and 1 stores 4 registers starting at bits[4:2] times 4. The remaining registers follow consecutively.
- R2: The first element address is base + sext(bits[19:16]) × group size × (VL/8) bytes.
- R3: Elements are visited register by register, lowest lane first. The address advances by 4 for every position, so flat position k writes to start + 4k with lane k mod (VL/32) of register first + k/(VL/32).
- R4: Flat position k writes only when k < pred_count. A count larger than the group makes every element active, and positions at or above the count issue no write.
- R5: pred_sel shows the governing predicate register number {1, bits[12:10]}, which is always in the range 8 to 15.
- R6: If bits[9:5] equal 31 and base bits[3:0] are non-zero, with at least one active element, fault pulses for one cycle and no write is issued.
- R7: If bits[9:5] equal 31, the base is misaligned and pred_count is 0, a fault occurs only when sp_chk_empty is 1. Otherwise the walk completes with done.
- R8: While wr_valid is high and wr_ready is low, wr_valid, wr_addr and wr_data stay unchanged.
- R9: done pulses for exactly one cycle after the last position of the group is passed. done and fault are never high together.
- R10: A start pulse that arrives while a walk is in progress is ignored.
- R11: A base from a general register (bits[9:5] not 31) is never alignment-checked.
- R12: After reset, wr_valid, done and fault are low.
- R13: A start whose word does not match the opcode is ignored. The opcode requires bits[31:20]=0xA06, bits[14:13]=2'b10 and bit 0 = 0, and in the 4-register form also bit 1 = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a store using the current instr |
| instr | input | 32 | Store instruction word |
| base_val | input | 64 | Base value (general register or stack pointer) |
| pred_count | input | CNTW | Number of leading active elements in the group |
| sp_chk_empty | input | 1 | Perform the stack pointer check even with no active element |
| pred_sel | output | 4 | Governing predicate register number |
| vreg_idx | output | 5 | Vector register read index |
| vreg_data | input | VL | Vector register read data |
| wr_valid | output | 1 | Write request valid |
| wr_addr | output | 64 | Write byte address |
| wr_data | output | 32 | Write data word |
| wr_ready | input | 1 | Memory accepts the request |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | One-cycle alignment fault pulse |

## Verification
The store is exercised with a full pair, a full quad under a stalling ready pattern, a partial count, and an oversized count. Together these separate group sizing, negative and positive immediate scaling, and address advance across inactive positions, and show that the handshake holds its request. Stack pointer bases are tried aligned, misaligned with active elements, and misaligned and empty under both settings of the configuration input. This tells the alignment decision apart from the mask. A misaligned general register base, a start issued while busy and a malformed word each probe a case where nothing must change.

// File: rtl/vst_pkg.sv
package vst_pkg;
    typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} vst_state_e;
    localparam logic [11:0] OPC_HI = 12'hA06;
endpackage

// File: rtl/vst_decode.sv
module vst_decode #(
    parameter int REGB = 16
) (
    input  logic [31:0] instr,
    output logic        match,
    output logic        quad,
    output logic [4:0]  first,
    output logic [3:0]  pred_sel,
    output logic        rn_is_sp,
    output logic [63:0] offset
);
    import vst_pkg::*;

    logic [63:0] imm_ext;
    logic [63:0] grp_bytes;

    always_comb begin
        quad     = instr[15];
        match    = (instr[31:20] == OPC_HI) && (instr[14:13] == 2'b10) &&
                   !instr[0] && (!quad || !instr[1]);
        first    = quad ? {instr[4:2], 2'b00} : {instr[4:1], 1'b0};
        pred_sel = {1'b1, instr[12:10]};
        rn_is_sp = (instr[9:5] == 5'd31);
        imm_ext  = {{60{instr[19]}}, instr[19:16]};
        grp_bytes = quad ? 64'(4 * REGB) : 64'(2 * REGB);
        offset   = imm_ext * grp_bytes;
    end
endmodule

// File: rtl/vst_align.sv
module vst_align #(
    parameter int ALW = 4
) (
    input  logic           rn_is_sp,
    input  logic [ALW-1:0] base_lo,
    input  logic           any_active,
    input  logic           chk_empty,
    output logic           fault
);
    always_comb begin
        fault = rn_is_sp && (base_lo != '0) && (any_active || chk_empty);
    end
endmodule

// File: rtl/vst_lane_sel.sv
module vst_lane_sel #(
    parameter int VL    = 128,
    parameter int ELEMS = VL / 32,
    parameter int IDXW  = 4
) (
    input  logic [IDXW-1:0] idx,
    input  logic [4:0]      first,
    input  logic [VL-1:0]   vreg_data,
    output logic [4:0]      vreg_idx,
    output logic [31:0]     word
);
    localparam int LANEW = $clog2(ELEMS);

    logic [IDXW-1:0]  reg_off;
    logic [LANEW-1:0] lane;

    always_comb begin
        reg_off  = idx >> LANEW;
        lane     = idx[LANEW-1:0];
        vreg_idx = first + 5'(reg_off);
        word     = vreg_data[32*lane +: 32];
    end
endmodule

// File: rtl/vstore_seq.sv
module vstore_seq #(
    parameter int  VL    = 128,
    localparam int ELEMS = VL / 32,
    localparam int REGB  = VL / 8,
    localparam int TOT   = 4 * ELEMS,
    localparam int IDXW  = $clog2(TOT),
    localparam int CNTW  = $clog2(TOT + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [31:0]     instr,
    input  logic [63:0]     base_val,
    input  logic [CNTW-1:0] pred_count,
    input  logic            sp_chk_empty,
    output logic [3:0]      pred_sel,
    output logic [4:0]      vreg_idx,
    input  logic [VL-1:0]   vreg_data,
    output logic            wr_valid,
    output logic [63:0]     wr_addr,
    output logic [31:0]     wr_data,
    input  logic            wr_ready,
    output logic            done,
    output logic            fault
);
    import vst_pkg::*;

    localparam int ALW = 4;

    typedef struct packed {
        vst_state_e      st;
        logic            quad;
        logic [4:0]      first;
        logic [63:0]     addr;
        logic [IDXW-1:0] idx;
        logic [CNTW-1:0] cnt;
        logic            done;
        logic            fault;
    } seq_t;

    seq_t r_q, r_d;

    logic        dec_match, dec_quad, dec_sp, align_flt, active;
    logic [4:0]  dec_first;
    logic [63:0] dec_off;
    logic [31:0] lane_word;
    logic [IDXW-1:0] last_idx;

    vst_decode #(.REGB(REGB)) u_dec (
        .instr    (instr),
        .match    (dec_match),
        .quad     (dec_quad),
        .first    (dec_first),
        .pred_sel (pred_sel),
        .rn_is_sp (dec_sp),
        .offset   (dec_off)
    );

    vst_align #(.ALW(ALW)) u_align (
        .rn_is_sp   (dec_sp),
        .base_lo    (base_val[ALW-1:0]),
        .any_active (pred_count != '0),
        .chk_empty  (sp_chk_empty),
        .fault      (align_flt)
    );

    vst_lane_sel #(.VL(VL), .ELEMS(ELEMS), .IDXW(IDXW)) u_lane (
        .idx       (r_q.idx),
        .first     (r_q.first),
        .vreg_data (vreg_data),
        .vreg_idx  (vreg_idx),
        .word      (lane_word)
    );

    always_comb begin
        r_d       = r_q;
        r_d.done  = 1'b0;
        r_d.fault = 1'b0;
        active    = (CNTW'(r_q.idx) < r_q.cnt);
        last_idx  = r_q.quad ? IDXW'(TOT - 1) : IDXW'(TOT / 2 - 1);

        case (r_q.st)
            ST_IDLE: begin
                if (start && dec_match) begin
                    if (align_flt) begin
                        r_d.fault = 1'b1;
                    end else begin
                        r_d.st    = ST_RUN;
                        r_d.quad  = dec_quad;
                        r_d.first = dec_first;
                        r_d.addr  = base_val + dec_off;
                        r_d.idx   = '0;
                        r_d.cnt   = pred_count;
                    end
                end
            end
            ST_RUN: begin
                if (!active || wr_ready) begin
                    r_d.addr = r_q.addr + 64'd4;
                    if (r_q.idx == last_idx) begin
                        r_d.st   = ST_IDLE;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase

        wr_valid = (r_q.st == ST_RUN) && active;
        wr_addr  = r_q.addr;
        wr_data  = lane_word;
        done     = r_q.done;
        fault    = r_q.fault;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end
endmodule

// File: rtl/vstore_seq_chk.sv
module vstore_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_valid,
    input logic        wr_ready,
    input logic [63:0] wr_addr,
    input logic [31:0] wr_data,
    input logic        done,
    input logic        fault
);
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

    assert_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, fault}));

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_fault_nowr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !wr_valid);

    assert_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && wr_ready) |=> (!wr_valid || (wr_addr != $past(wr_addr))));
endmodule

bind vstore_seq vstore_seq_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .done     (done),
    .fault    (fault)
);

// File: tb/vstore_seq_test.sv
module vstore_seq_test;
    localparam int VL    = 128;
    localparam int ELEMS = VL / 32;
    localparam int CNTW  = $clog2(4 * ELEMS + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [31:0]     instr = '0;
    logic [63:0]     base_val = '0;
    logic [CNTW-1:0] pred_count = '0;
    logic            sp_chk_empty = 1'b0;
    logic [3:0]      pred_sel;
    logic [4:0]      vreg_idx;
    logic [VL-1:0]   vreg_data;
    logic            wr_valid;
    logic [63:0]     wr_addr;
    logic [31:0]     wr_data;
    logic            wr_ready = 1'b1;
    logic            done, fault;

    vstore_seq #(.VL(VL)) uut (.*);

    always #5 clk = ~clk;

    typedef struct packed { logic [63:0] a; logic [31:0] d; } item_t;
    item_t q[$];

    int n_checks = 0, n_fail = 0, n_done = 0, n_fault = 0, cyc = 0;
    bit slow = 1'b0, finished = 1'b0;

    function automatic logic [31:0] wd(input logic [4:0] r, input int e);
        return {8'hA5, 3'b000, r, 8'(e), 8'h3C};
    endfunction

    always_comb begin
        for (int e = 0; e < ELEMS; e++) vreg_data[32*e +: 32] = wd(vreg_idx, e);
    end

    always @(negedge clk) begin
        cyc <= cyc + 1;
        wr_ready <= slow ? ((cyc % 3) != 1) : 1'b1;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // monitor: compare each accepted write with the scoreboard (R1 R2 R3 R4)
    always @(negedge clk) begin
        #2;
        if (rst_n) begin
            if (wr_valid && wr_ready) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R4 unexpected write", wr_addr, 64'h0);
                end else begin
                    item_t it;
                    it = q.pop_front();
                    chk(wr_addr == it.a, "R2/R3 addr", wr_addr, it.a);
                    chk(wr_data == it.d, "R1/R3 data", {32'h0, wr_data}, {32'h0, it.d});
                end
            end
            if (done) n_done++;
            if (fault) n_fault++;
        end
    end

    function automatic logic [31:0] mk(input bit qd, input logic [3:0] imm, input logic [2:0] png,
                                       input logic [4:0] rn, input logic [3:0] zt);
        logic [4:0] z5;
        z5 = qd ? {zt[2:0], 2'b00} : {zt[3:0], 1'b0};
        return {12'hA06, imm, qd, 2'b10, png, rn, z5};
    endfunction

    task automatic run_op(input string tag, input bit qd, input logic [3:0] imm, input logic [4:0] rn,
                          input logic [3:0] zt, input logic [63:0] base, input int cnt,
                          input bit cfg, input bit poke);
        int nreg, tot, nact, d0, f0, waited;
        logic [4:0] first;
        logic [63:0] a0;
        longint off;
        bit exp_flt;
        nreg  = qd ? 4 : 2;
        tot   = nreg * ELEMS;
        nact  = (cnt < tot) ? cnt : tot;
        first = qd ? {zt[2:0], 2'b00} : {zt[3:0], 1'b0};
        off   = longint'($signed(imm)) * nreg * (VL / 8);
        a0    = base + 64'(off);
        exp_flt = (rn == 5'd31) && (base[3:0] != 4'h0) && ((cnt != 0) || cfg);
        if (!exp_flt)
            for (int k = 0; k < nact; k++)
                q.push_back('{a: a0 + 64'(4 * k), d: wd(5'(first + 5'(k / ELEMS)), k % ELEMS)});
        d0 = n_done; f0 = n_fault;
        @(negedge clk);
        instr = mk(qd, imm, 3'd2, rn, zt);
        base_val = base; pred_count = CNTW'(cnt); sp_chk_empty = cfg; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        waited = 0;
        while ((n_done == d0) && (n_fault == f0) && (waited < 300)) begin
            @(negedge clk); #3;
            waited++;
            if (poke && waited == 3) begin
                // R10: second start during the walk
                instr = mk(1'b0, 4'h1, 3'd0, 5'd4, 4'd9);
                base_val = 64'h9999_0000; pred_count = CNTW'(8); start = 1'b1;
                @(negedge clk); start = 1'b0;
            end
        end
        chk(waited < 300, {tag, " completion"}, 64'(waited), 64'd300);
        repeat (poke ? 20 : 3) @(negedge clk);
        #3;
        chk((n_done - d0) == (exp_flt ? 0 : 1), {tag, " R9 done pulses"}, 64'(n_done - d0), exp_flt ? 64'd0 : 64'd1);
        chk((n_fault - f0) == (exp_flt ? 1 : 0), {tag, " R6 fault pulses"}, 64'(n_fault - f0), exp_flt ? 64'd1 : 64'd0);
        chk(q.size() == 0, {tag, " R4 writes missing"}, 64'(q.size()), 64'd0);
        q.delete();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #3;
        chk(!wr_valid && !done && !fault, "R12 reset outputs", {61'h0, wr_valid, done, fault}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        instr = mk(1'b0, 4'h0, 3'd5, 5'd1, 4'd0);
        #1;
        chk(pred_sel == 4'hD, "R5 predicate number", 64'(pred_sel), 64'hD);

        run_op("R1 R2 pair full", 1'b0, 4'h0, 5'd2, 4'd3, 64'h1000, 8, 1'b0, 1'b0);
        slow = 1'b1;
        run_op("R2 R8 quad neg imm slow", 1'b1, 4'hD, 5'd7, 4'd1, 64'h8000, 16, 1'b0, 1'b0);
        run_op("R3 R4 quad partial", 1'b1, 4'h7, 5'd7, 4'd5, 64'h2_0000, 5, 1'b0, 1'b0);
        slow = 1'b0;
        run_op("R4 pair oversize count", 1'b0, 4'h8, 5'd0, 4'd15, 64'h5_0000, 20, 1'b0, 1'b0);
        run_op("R6 sp misaligned", 1'b1, 4'h0, 5'd31, 4'd0, 64'h2004, 3, 1'b0, 1'b0);
        run_op("R6 sp aligned", 1'b0, 4'h2, 5'd31, 4'd2, 64'h3000, 4, 1'b0, 1'b0);
        run_op("R7 sp empty nochk", 1'b0, 4'h0, 5'd31, 4'd1, 64'h3008, 0, 1'b0, 1'b0);
        run_op("R7 sp empty chk", 1'b1, 4'h0, 5'd31, 4'd1, 64'h3008, 0, 1'b1, 1'b0);
        run_op("R11 gpr misaligned", 1'b0, 4'h1, 5'd5, 4'd4, 64'h4003, 6, 1'b1, 1'b0);
        slow = 1'b1;
        run_op("R10 busy start", 1'b1, 4'h1, 5'd3, 4'd6, 64'h6000, 16, 1'b0, 1'b1);
        slow = 1'b0;

        begin : bad_word
            int d0;
            d0 = n_done;
            @(negedge clk);
            instr = mk(1'b0, 4'h0, 3'd0, 5'd1, 4'd0) ^ 32'h0000_4000;
            pred_count = CNTW'(4); start = 1'b1;
            @(negedge clk); start = 1'b0;
            repeat (20) @(negedge clk);
            #3;
            chk(n_done == d0, "R13 malformed word ignored", 64'(n_done - d0), 64'd0);
            chk(q.size() == 0, "R13 no writes", 64'(q.size()), 64'd0);
        end

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #500000;
        if (!finished) begin
            finished = 1'b1;
            n_checks++; n_fail++;
            $display("FAIL watchdog act=%h exp=%h", 64'h1, 64'h0);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule